// File: doc/BRIEF.md
# Four-by-four matrix-vector transform sequencer

This block multiplies a four-by-four matrix of 32-bit words by a four-element vector. The matrix sits in a sixteen-word coefficient bank, written one word at a time. The vector sits in four front registers, which can be read and written through a small register port. A transform request sends the front vector and one matrix row at a time into a three-stage, four-lane dot-product pipeline. It then writes the four results back over the front registers. The transform is therefore done in place: element i of the front vector becomes the dot product of the old vector with row i.

Rows issue on four consecutive cycles. Every row has to see the unmodified input vector, so the block latches the front vector and the coefficient bank when it accepts a request. It keeps the first three results until the fourth one arrives, and then commits all four on the same clock edge. A new request can be accepted every four cycles, so two transforms can overlap in the pipeline.

The request uses a valid/ready pair. The block samples `start_valid` only on an edge where `start_ready` is high. A request seen while `start_ready` is low is not queued: the requester has to hold `start_valid` until it sees ready, or the request is lost. The bank and vector ports are plain register writes with no flow control. In this build the datapath uses 32-bit two's-complement arithmetic with wrap-around, as a fixed-point stand-in for the floating-point multiply-add stage.

Top module: `mtx4_xform`

## Requirements
- R1: After reset, `busy` and `done` are 0, `start_ready` is 1, and all four front registers and all sixteen bank words read as 0.
- R2: A front write (`vec_we`, `vec_addr`, `vec_wdata`) outside a commit edge updates that register, and `vec_rdata` shows front register `vec_raddr` without delay.
- R3: Bank word 4*i+k (`bank_addr` = {i,k}) is coefficient k of row i. Result i equals f0*b(4i)+f1*b(4i+1)+f2*b(4i+2)+f3*b(4i+3), computed modulo 2^32, and rows issue in order 0, 1, 2, 3.
- R4: Result i replaces front register i. All four registers change together on the commit edge, and every row uses the front vector as it stood when the request was accepted.
- R5: A request accepted on edge n commits on edge n+7, and `done` is high for the cycle that follows that edge.
- R6: `busy` is high from the cycle after acceptance until the commit edge of the last outstanding transform.
- R7: `start_ready` is low during the three cycles after an acceptance. A request made then is ignored and produces no transform.
- R8: Requests can be accepted every four cycles. Their `done` pulses then come four cycles apart, and at most two transforms are in flight at once.
- R9: A bank write sampled on or after the acceptance edge does not change that transform's result. It does change the result of transforms accepted later.
- R10: On a commit edge the commit has priority, and a front write sampled on that same edge is lost.
- R11: `done` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Transform request |
| start_ready | output | 1 | Request can be accepted on this edge |
| busy | output | 1 | At least one transform not yet committed |
| done | output | 1 | One-cycle pulse after a commit |
| bank_we | input | 1 | Coefficient bank write enable |
| bank_addr | input | 4 | Bank word index {row, lane} |
| bank_wdata | input | 32 | Bank write data |
| vec_we | input | 1 | Front register write enable |
| vec_addr | input | 2 | Front register write index |
| vec_wdata | input | 32 | Front register write data |
| vec_raddr | input | 2 | Front register read index |
| vec_rdata | output | 32 | Front register read data |

## Verification
A wrong internal state always surfaces at the front registers or on the control pins within one transform. A lost snapshot or an early write-back shows up as wrong products in the rows after row 0, which can be read seven cycles after the request. A wrong row counter or a wrong pipeline tag puts results in the wrong slot, or moves `done` away from edge n+7. A miscounted in-flight total leaves `busy` high or drops it early, which is visible within the next four cycles. Overlapping requests, requests made while ready is low, bank writes during a transform, and front writes on the commit edge each target one of these paths.

// File: rtl/mtx_pkg.sv
`timescale 1ns/1ps
package mtx_pkg;
  localparam int DIM  = 4;
  localparam int IDXW = $clog2(DIM);
  localparam int BANK = DIM * DIM;
  localparam int BAW  = $clog2(BANK);
  typedef logic [IDXW-1:0] idx_t;
  localparam idx_t LAST = idx_t'(DIM - 1);
endpackage

// File: rtl/mtx_bank.sv
`timescale 1ns/1ps
module mtx_bank
  import mtx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [BAW-1:0]          waddr,
  input  logic [DW-1:0]           wdata,
  input  logic                    snap,
  input  idx_t                    row_i,
  output logic [DIM-1:0][DW-1:0]  row_o
);
  // live words take writes; the shadow copy feeds the rows of a running transform
  logic [BANK-1:0][DW-1:0] live_q, shad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      shad_q <= '0;
    end else begin
      if (we)   live_q[waddr] <= wdata;
      if (snap) shad_q <= live_q;
    end
  end

  for (genvar g = 0; g < DIM; g++) begin : g_lane
    assign row_o[g] = shad_q[{row_i, idx_t'(g)}];
  end
endmodule

// File: rtl/mtx_dot4.sv
`timescale 1ns/1ps
module mtx_dot4
  import mtx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  idx_t                    in_tag,
  input  logic [DIM-1:0][DW-1:0]  a_i,
  input  logic [DIM-1:0][DW-1:0]  b_i,
  output logic                    out_vld,
  output idx_t                    out_tag,
  output logic [DW-1:0]           out_sum
);
  localparam int HALF = DIM / 2;
  localparam int STG  = 3;

  logic [DIM-1:0][DW-1:0]  prod_q;
  logic [HALF-1:0][DW-1:0] pair_q;
  logic [DW-1:0]           sum_q;
  logic [STG-1:0]          vld_q;
  idx_t                    tag_q [STG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      pair_q <= '0;
      sum_q  <= '0;
      vld_q  <= '0;
      for (int s = 0; s < STG; s++) tag_q[s] <= '0;
    end else begin
      for (int k = 0; k < DIM; k++)  prod_q[k] <= a_i[k] * b_i[k];
      for (int k = 0; k < HALF; k++) pair_q[k] <= prod_q[2*k] + prod_q[2*k+1];
      sum_q <= pair_q[0] + pair_q[1];
      vld_q <= {vld_q[STG-2:0], in_vld};
      tag_q[0] <= in_tag;
      for (int s = 1; s < STG; s++) tag_q[s] <= tag_q[s-1];
    end
  end

  assign out_vld = vld_q[STG-1];
  assign out_tag = tag_q[STG-1];
  assign out_sum = sum_q;

  AST_DOT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 3)); // R5
  AST_DOT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_tag == $past(in_tag, 3)); // R3
endmodule

// File: rtl/mtx_seq.sv
`timescale 1ns/1ps
module mtx_seq
  import mtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_valid,
  output logic start_ready,
  output logic accept,
  output logic issue_vld,
  output idx_t issue_row,
  input  logic commit,
  output logic busy
);
  logic       iss_q;
  idx_t       row_q;
  logic [1:0] infl_q;

  // ready again in the cycle that issues the last row
  assign start_ready = !iss_q || (row_q == LAST);
  assign accept      = start_valid && start_ready;
  assign issue_vld   = iss_q;
  assign issue_row   = row_q;
  assign busy        = (infl_q != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_q  <= 1'b0;
      row_q  <= '0;
      infl_q <= '0;
    end else begin
      if (accept) begin
        iss_q <= 1'b1;
        row_q <= '0;
      end else if (iss_q) begin
        row_q <= row_q + 1'b1;
        if (row_q == LAST) iss_q <= 1'b0;
      end
      case ({accept, commit})
        2'b10:   infl_q <= infl_q + 2'd1;
        2'b01:   infl_q <= infl_q - 2'd1;
        default: infl_q <= infl_q;
      endcase
    end
  end

  AST_START_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !$past(accept) && !$past(accept, 2) && !$past(accept, 3)); // R7
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    infl_q <= 2'd2); // R8
  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && issue_row != LAST |=> issue_vld && issue_row == $past(issue_row) + 1'b1); // R3
endmodule

// File: rtl/mtx4_xform.sv
`timescale 1ns/1ps
module mtx4_xform
  import mtx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_valid,
  output logic           start_ready,
  output logic           busy,
  output logic           done,
  input  logic           bank_we,
  input  logic [BAW-1:0] bank_addr,
  input  logic [DW-1:0]  bank_wdata,
  input  logic           vec_we,
  input  idx_t           vec_addr,
  input  logic [DW-1:0]  vec_wdata,
  input  idx_t           vec_raddr,
  output logic [DW-1:0]  vec_rdata
);
  logic                   accept, issue_vld, commit, dot_vld, done_q;
  idx_t                   issue_row, dot_tag;
  logic [DW-1:0]          dot_sum;
  logic [DIM-1:0][DW-1:0] front_q, fsnap_q, row_w;
  logic [DIM-2:0][DW-1:0] hold_q;

  assign commit = dot_vld && (dot_tag == LAST);

  mtx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .accept(accept), .issue_vld(issue_vld), .issue_row(issue_row),
    .commit(commit), .busy(busy)
  );

  mtx_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .waddr(bank_addr), .wdata(bank_wdata),
    .snap(accept), .row_i(issue_row), .row_o(row_w)
  );

  mtx_dot4 #(.DW(DW)) u_dot (
    .clk(clk), .rst_n(rst_n), .in_vld(issue_vld), .in_tag(issue_row),
    .a_i(fsnap_q), .b_i(row_w),
    .out_vld(dot_vld), .out_tag(dot_tag), .out_sum(dot_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_q <= '0;
      fsnap_q <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) fsnap_q <= front_q;
      if (dot_vld && dot_tag != LAST) hold_q[dot_tag] <= dot_sum;
      if (commit) begin
        for (int k = 0; k < DIM-1; k++) front_q[k] <= hold_q[k];
        front_q[DIM-1] <= dot_sum;
      end else if (vec_we) begin
        front_q[vec_addr] <= vec_wdata;
      end
      done_q <= commit;
    end
  end

  assign done      = done_q;
  assign vec_rdata = front_q[vec_raddr];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R6
  AST_FRONT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !$past(vec_we) |-> $stable(front_q)); // R4
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> start_ready); // R7
endmodule

// File: tb/mtx4_xform_test.sv
`timescale 1ns/1ps
module mtx4_xform_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_valid = 1'b0, bank_we = 1'b0, vec_we = 1'b0;
  logic [3:0]  bank_addr = '0;
  logic [1:0]  vec_addr = '0, vec_raddr = '0;
  logic [31:0] bank_wdata = '0, vec_wdata = '0;
  logic        start_ready, busy, done;
  logic [31:0] vec_rdata;

  mtx4_xform uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .busy(busy), .done(done), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .vec_we(vec_we), .vec_addr(vec_addr),
    .vec_wdata(vec_wdata), .vec_raddr(vec_raddr), .vec_rdata(vec_rdata)
  );

  always #4 clk = ~clk;

  typedef struct packed { logic [3:0][31:0] v; int cyc; } exp_t;
  exp_t        sb[$];
  logic [31:0] mb [16];
  logic [31:0] mf [4];
  int cyc = 0, nchk = 0, nfail = 0, ndone = 0, nacc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    vec_raddr = a;
    #0.5;
    d = vec_rdata;
  endtask

  task automatic bank_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bank_we = 1'b1; bank_addr = 4'(a); bank_wdata = d; mb[a] = d;
    @(negedge clk);
    bank_we = 1'b0;
  endtask

  task automatic vec_wr(input int a, input logic [31:0] d, input bit model);
    @(negedge clk);
    vec_we = 1'b1; vec_addr = 2'(a); vec_wdata = d;
    if (model) mf[a] = d;
    @(negedge clk);
    vec_we = 1'b0;
  endtask

  // driver: request one transform; push the expected result if accepted
  task automatic go(output bit acc);
    exp_t e;
    @(negedge clk);
    start_valid = 1'b1;
    acc = start_ready;
    if (acc) begin
      for (int i = 0; i < 4; i++) begin
        e.v[i] = '0;
        for (int k = 0; k < 4; k++) e.v[i] = e.v[i] + mf[k] * mb[4*i+k];
      end
      e.cyc = cyc + 1;
      sb.push_back(e);
      nacc++;
    end
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  // monitor: pop on each done, compare the front registers and the timing
  initial begin
    logic [31:0] d;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        ndone++;
        if (sb.size() == 0) begin
          nchk++; nfail++;
          $display("FAIL R11 actual=done expected=no_done");
        end else begin
          e = sb.pop_front();
          chk("R5 commit edge", 32'(cyc), 32'(e.cyc + 7));
          for (int i = 0; i < 4; i++) begin
            rd(2'(i), d);
            chk($sformatf("R3/R4 result %0d", i), d, e.v[i]);
            mf[i] = e.v[i];
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    bit a1, a2;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) mb[i] = '0;
    for (int i = 0; i < 4; i++) mf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 start_ready", 32'(start_ready), 1);
    for (int i = 0; i < 4; i++) begin rd(2'(i), d); chk("R1 front", d, 0); end
    go(a1);                         // zero bank, zero vector
    repeat (9) @(negedge clk);

    // R2 write and read back
    for (int i = 0; i < 4; i++) vec_wr(i, 32'(i + 1), 1);
    for (int i = 0; i < 4; i++) begin rd(2'(i), d); chk("R2 readback", d, 32'(i + 1)); end

    // R3 distinct coefficients in every word
    for (int i = 0; i < 16; i++) bank_wr(i, 32'(3 * i + 1));
    go(a1);
    chk("R6 busy during", 32'(busy), 1);
    chk("R7 ready low after accept", 32'(start_ready), 0);
    repeat (9) @(negedge clk);
    chk("R6 busy after", 32'(busy), 0);

    // identity matrix keeps the vector
    for (int i = 0; i < 16; i++) bank_wr(i, (i % 5 == 0) ? 32'd1 : 32'd0);
    go(a1);
    repeat (9) @(negedge clk);

    // negative values and wrap-around
    vec_wr(0, 32'hFFFF_FFFD, 1); vec_wr(1, 32'h7FFF_FFFF, 1);
    vec_wr(2, 32'h0001_0000, 1); vec_wr(3, 32'hFFFF_FFFF, 1);
    for (int i = 0; i < 16; i++) bank_wr(i, 32'h1234_5678 * 32'(i + 1) - 32'(i * 7));
    go(a1);
    repeat (9) @(negedge clk);

    // R7 request while not ready is ignored
    go(a1);
    go(a2);
    chk("R7 second accepted", 32'(a2), 0);
    repeat (12) @(negedge clk);
    chk("R7 done count", 32'(ndone), 32'(nacc));

    // R8 back-to-back, R9 bank write during transform
    go(a1);
    bank_wr(13, 32'h0000_0009);     // row 3 lane 1 changes after acceptance
    go(a2);                         // sampled four edges after the first
    chk("R8 back-to-back accepted", 32'(a2), 1);
    repeat (14) @(negedge clk);
    go(a1);                         // R9 sees the new word
    repeat (9) @(negedge clk);

    // R10 front write on the commit edge is lost
    go(a1);
    repeat (5) @(negedge clk);
    vec_wr(2, 32'hDEAD_BEEF, 0);
    repeat (6) @(negedge clk);
    chk("R11 all requests done", 32'(ndone), 32'(nacc));
    chk("R11 scoreboard empty", 32'(sb.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule